// File: doc/BRIEF.md
# Half-Bridge Gate Control Sequencer

This block is the synchronous decision logic in front of a half-bridge gate driver. A controller supplies two active-high commands, one for the upper switch and one for the lower switch. The block passes each command straight to its drive enable, with no inversion. It also applies a shoot-through interlock and gates both enables off for supply undervoltage, boot-supply undervoltage and over-temperature. It enables the bootstrap charging switch only while the upper switch is off.

The block has two states. In ST_ACTIVE the commands drive the outputs. In ST_SLEEP both enables are off, the upper output is reported as high-impedance and the lower output is pulled low.

There are three ways into sleep, and each one is the transition ACTIVE->SLEEP:
- Both commands are held high for a set number of cycles.
- Supply undervoltage lasts a set number of cycles.
- The debounced enable line goes low.

There is only one way out, the transition SLEEP->ACTIVE. The upper command must be low and the lower command high, held for a set number of cycles, while the enable is high and the supply is healthy.

All intervals are given in clock cycles as parameters.

Top module: `hb_gate_seq`

## Requirements
- R1: After reset, hi_drv=0, lo_drv=0, sleep_o=0, hi_hiz=0, lo_pulldn=0 and boot_sw_en=1. The filtered enable starts high.
- R2: In ST_ACTIVE with no fault, hi_drv equals hi_cmd when lo_cmd=0, and lo_drv equals lo_cmd when hi_cmd=0, in the same cycle and with no inversion.
- R3: When hi_cmd=1 and lo_cmd=1, both drives are 0. A second command rising while the first is high never reaches its output. When the first command drops, the other output turns on in that same cycle, with no added dead time.
- R4: hi_cmd=lo_cmd=1 sampled on SLEEP_SET_CYC consecutive clock edges moves ACTIVE->SLEEP at the last of those edges. Any break in the pattern restarts the count.
- R5: SLEEP->ACTIVE occurs only after hi_cmd=0 and lo_cmd=1 are sampled on SLEEP_CLR_CYC consecutive edges, with the filtered enable high and vdd_uv=0 at the final edge. Every other input pattern leaves the block in sleep.
- R6: vdd_uv=1 forces hi_drv=lo_drv=0 and lo_pulldn=1 in the same cycle. If vdd_uv is sampled high on UV_SLEEP_CYC consecutive edges, the block enters sleep.
- R7: While sleep_o=1: hi_hiz=1, lo_pulldn=1, hi_drv=0, lo_drv=0 and boot_sw_en=0.
- R8: The filtered enable takes the level of drv_en only after drv_en has differed from it on EN_DEB_CYC consecutive edges; shorter glitches are ignored. A filtered low moves the block into sleep.
- R9: boot_sw_en=1 exactly when hi_drv=0 and sleep_o=0.
- R10: boot_uv=1 forces hi_drv=0 in the same cycle. If boot_uv is seen while the upper switch would be driven, hi_drv stays 0 after boot_uv clears, until hi_cmd has been low on a clock edge.
- R11: ot_flag=1 forces both drives to 0 and lo_pulldn=1 without entering sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 1 | Upper-switch command |
| lo_cmd | input | 1 | Lower-switch command |
| vdd_uv | input | 1 | Driver supply undervoltage |
| boot_uv | input | 1 | Boot supply undervoltage |
| ot_flag | input | 1 | Over-temperature |
| drv_en | input | 1 | Raw driver enable line, debounced inside |
| hi_drv | output | 1 | Upper gate drive enable |
| lo_drv | output | 1 | Lower gate drive enable |
| sleep_o | output | 1 | Block is in ST_SLEEP |
| hi_hiz | output | 1 | Upper output is high-impedance |
| lo_pulldn | output | 1 | Strong pull-down on lower output |
| boot_sw_en | output | 1 | Bootstrap charging switch enable |

## Verification
Several command patterns are applied:
- Single commands, which show that the outputs follow the inputs with no inversion.
- Overlapping commands, which separate the interlock's both-high blocking from the zero-dead-time handover.
- Both-high runs cut one cycle short and then held to full length, which locate the exact sleep-entry edge.
- Wake patterns interrupted by other patterns, which show that only an unbroken one-sided run clears sleep.

Undervoltage runs, enable glitches, boot-undervoltage pulses and over-temperature are each applied both shorter and longer than their windows. This distinguishes immediate gating from timed sleep entry and from the latched upper-side trip.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
    typedef enum logic {
        ST_ACTIVE = 1'b0,
        ST_SLEEP  = 1'b1
    } hb_state_e;
endpackage

// File: rtl/hb_run_timer.sv
// Counts consecutive edges on which pat is high; hit when the LIMIT-th is reached.
module hb_run_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pat,
    output logic hit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!pat) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = pat & (cnt_q == LAST);
endmodule

// File: rtl/hb_en_filter.sv
// Level filter: output adopts raw after LIMIT consecutive differing edges.
module hb_en_filter #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= 1'b1;
        end else if (raw == lvl_q) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            lvl_q <= raw;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign level = lvl_q;
endmodule

// File: rtl/hb_drive_gate.sv
// Interlock, fault gating and latched boot-supply trip for the upper side.
module hb_drive_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic block,
    input  logic boot_uv,
    output logic hi_drv,
    output logic lo_drv
);
    logic hi_pass;
    logic trip_q;

    assign hi_pass = hi_cmd & ~lo_cmd & ~block;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else begin
            trip_q <= hi_cmd & (trip_q | (hi_pass & boot_uv));
        end
    end

    assign hi_drv = hi_pass & ~boot_uv & ~trip_q;
    assign lo_drv = lo_cmd & ~hi_cmd & ~block;
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq
    import hb_gate_pkg::*;
#(
    parameter int SLEEP_SET_CYC = 5000,
    parameter int SLEEP_CLR_CYC = 5000,
    parameter int UV_SLEEP_CYC  = 7500,
    parameter int EN_DEB_CYC    = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic vdd_uv,
    input  logic boot_uv,
    input  logic ot_flag,
    input  logic drv_en,
    output logic hi_drv,
    output logic lo_drv,
    output logic sleep_o,
    output logic hi_hiz,
    output logic lo_pulldn,
    output logic boot_sw_en
);
    hb_state_e st_q, st_d;
    logic set_hit, clr_hit, uv_hit, en_lvl;
    logic in_sleep, block;

    hb_run_timer #(.LIMIT(SLEEP_SET_CYC)) i_set_tmr (
        .clk(clk), .rst_n(rst_n), .pat(hi_cmd & lo_cmd), .hit(set_hit));

    hb_run_timer #(.LIMIT(SLEEP_CLR_CYC)) i_clr_tmr (
        .clk(clk), .rst_n(rst_n), .pat(~hi_cmd & lo_cmd), .hit(clr_hit));

    hb_run_timer #(.LIMIT(UV_SLEEP_CYC)) i_uv_tmr (
        .clk(clk), .rst_n(rst_n), .pat(vdd_uv), .hit(uv_hit));

    hb_en_filter #(.LIMIT(EN_DEB_CYC)) i_en_flt (
        .clk(clk), .rst_n(rst_n), .raw(drv_en), .level(en_lvl));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_ACTIVE;
        else        st_q <= st_d;
    end

    // transitions: ACTIVE->SLEEP, SLEEP->ACTIVE
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_ACTIVE: if (set_hit | uv_hit | ~en_lvl)          st_d = ST_SLEEP;
            ST_SLEEP:  if (clr_hit & en_lvl & ~vdd_uv)          st_d = ST_ACTIVE;
        endcase
    end

    // outputs
    always_comb begin
        in_sleep   = 1'b0;
        unique case (st_q)
            ST_ACTIVE: in_sleep = 1'b0;
            ST_SLEEP:  in_sleep = 1'b1;
        endcase
        block      = in_sleep | vdd_uv | ot_flag;
        sleep_o    = in_sleep;
        hi_hiz     = in_sleep;
        lo_pulldn  = block;
        boot_sw_en = ~hi_drv & ~in_sleep;
    end

    hb_drive_gate i_drv (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .block(block), .boot_uv(boot_uv), .hi_drv(hi_drv), .lo_drv(lo_drv));
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic hi_cmd,
    input logic lo_cmd,
    input logic vdd_uv,
    input logic boot_uv,
    input logic ot_flag,
    input logic hi_drv,
    input logic lo_drv,
    input logic sleep_o,
    input logic hi_hiz,
    input logic lo_pulldn,
    input logic boot_sw_en
);
    a_r3_both_high_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_cmd && lo_cmd) |-> (!hi_drv && !lo_drv));

    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_drv && lo_drv));

    a_r5_wake_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleep_o) |-> $past(!hi_cmd && lo_cmd && !vdd_uv));

    a_r6_uv_gates: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_uv |-> (!hi_drv && !lo_drv && lo_pulldn));

    a_r7_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_o |-> (!hi_drv && !lo_drv && hi_hiz && lo_pulldn && !boot_sw_en));

    a_r9_boot_switch_off: assert property (@(posedge clk) disable iff (!rst_n)
        hi_drv |-> !boot_sw_en);

    a_r10_boot_uv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        boot_uv |-> !hi_drv);

    a_r11_overtemp: assert property (@(posedge clk) disable iff (!rst_n)
        ot_flag |-> (!hi_drv && !lo_drv && lo_pulldn));
endmodule

bind hb_gate_seq hb_gate_seq_chk i_chk (.*);

// File: tb/test_hb_gate_seq.sv
module test_hb_gate_seq;
    localparam int P_SET = 6;
    localparam int P_CLR = 5;
    localparam int P_UV  = 8;
    localparam int P_EN  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 0, lo_cmd = 0, vdd_uv = 0, boot_uv = 0, ot_flag = 0, drv_en = 1;
    logic hi_drv, lo_drv, sleep_o, hi_hiz, lo_pulldn, boot_sw_en;

    int vectors = 0;
    int fails = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    hb_gate_seq #(.SLEEP_SET_CYC(P_SET), .SLEEP_CLR_CYC(P_CLR),
                  .UV_SLEEP_CYC(P_UV), .EN_DEB_CYC(P_EN)) i_hb_gate_seq (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .vdd_uv(vdd_uv), .boot_uv(boot_uv), .ot_flag(ot_flag), .drv_en(drv_en),
        .hi_drv(hi_drv), .lo_drv(lo_drv), .sleep_o(sleep_o), .hi_hiz(hi_hiz),
        .lo_pulldn(lo_pulldn), .boot_sw_en(boot_sw_en));

    // behavioural reference: run lengths and flags
    int  set_run = 0, clr_run = 0, uv_run = 0, en_run = 0;
    bit  m_sleep = 0, m_en = 1, m_trip = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            set_run = 0; clr_run = 0; uv_run = 0; en_run = 0;
            m_sleep = 0; m_en = 1; m_trip = 0;
        end else begin
            bit old_sleep, old_en, blk, pass;
            old_sleep = m_sleep;
            old_en    = m_en;
            set_run = (hi_cmd && lo_cmd)  ? set_run + 1 : 0;
            clr_run = (!hi_cmd && lo_cmd) ? clr_run + 1 : 0;
            uv_run  = vdd_uv ? uv_run + 1 : 0;
            blk  = old_sleep || vdd_uv || ot_flag;
            pass = hi_cmd && !lo_cmd && !blk;
            m_trip = hi_cmd && (m_trip || (pass && boot_uv));
            if (!old_sleep) begin
                if (set_run >= P_SET || uv_run >= P_UV || !old_en) m_sleep = 1;
            end else begin
                if (clr_run >= P_CLR && old_en && !vdd_uv) m_sleep = 0;
            end
            if (drv_en != m_en) begin
                en_run = en_run + 1;
                if (en_run >= P_EN) begin
                    m_en = drv_en;
                    en_run = 0;
                end
            end else begin
                en_run = 0;
            end
        end
    end

    task automatic cmp(input string nm, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", cur_req, nm, act, exp, $time);
        end
    endtask

    // compare every cycle, 1 ns after the input change at the falling edge
    always @(negedge clk) begin
        #1;
        begin
            bit blk, e_hi, e_lo;
            if (!rst_n) begin
                blk = 0;
                e_hi = 0;
                e_lo = 0;
            end else begin
                blk  = m_sleep || vdd_uv || ot_flag;
                e_hi = hi_cmd && !lo_cmd && !blk && !boot_uv && !m_trip;
                e_lo = lo_cmd && !hi_cmd && !blk;
            end
            cmp("hi_drv", hi_drv, e_hi);
            cmp("lo_drv", lo_drv, e_lo);
            cmp("sleep_o", sleep_o, m_sleep);
            cmp("hi_hiz", hi_hiz, m_sleep);
            cmp("lo_pulldn", lo_pulldn, blk);
            cmp("boot_sw_en", boot_sw_en, !e_hi && !m_sleep);
        end
    end

    task automatic drive(input logic h, input logic l, input int n);
        @(negedge clk);
        hi_cmd = h;
        lo_cmd = l;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        drive(1, 0, 3); drive(0, 0, 2); drive(0, 1, 3); drive(0, 0, 2);

        cur_req = "R3";
        drive(1, 0, 2); drive(1, 1, 3); drive(0, 1, 2);  // handover, no dead time
        drive(1, 1, 2); drive(1, 0, 2); drive(0, 0, 2);

        cur_req = "R9";
        drive(1, 0, 1); drive(0, 0, 1); drive(1, 0, 2); drive(0, 0, 2);

        cur_req = "R4";
        drive(1, 1, P_SET - 1); drive(0, 0, 1);          // one short: stays active
        drive(1, 1, P_SET + 2);                          // enters sleep

        cur_req = "R7";
        drive(1, 0, 4); drive(0, 0, 3);

        cur_req = "R5";
        drive(0, 1, P_CLR - 1); drive(1, 0, 1);          // broken wake run
        drive(0, 1, P_CLR + 2);                          // wakes, lo drives
        drive(0, 0, 2);

        cur_req = "R6";
        @(negedge clk); vdd_uv = 1; hi_cmd = 1;
        repeat (3) @(negedge clk);
        vdd_uv = 0;
        repeat (2) @(negedge clk);
        hi_cmd = 0; vdd_uv = 1;
        repeat (P_UV + 3) @(negedge clk);
        lo_cmd = 1;
        repeat (P_CLR + 2) @(negedge clk);               // no wake while uv
        vdd_uv = 0;
        repeat (P_CLR + 2) @(negedge clk);
        lo_cmd = 0;
        repeat (2) @(negedge clk);

        cur_req = "R8";
        drv_en = 0;
        repeat (P_EN - 2) @(negedge clk);                // glitch ignored
        drv_en = 1;
        repeat (3) @(negedge clk);
        drv_en = 0;
        repeat (P_EN + 4) @(negedge clk);                // sleeps
        drv_en = 1;
        lo_cmd = 1;
        repeat (P_EN + P_CLR + 3) @(negedge clk);        // wakes after filter
        lo_cmd = 0;
        repeat (2) @(negedge clk);

        cur_req = "R10";
        drive(1, 0, 2);
        boot_uv = 1;
        repeat (2) @(negedge clk);
        boot_uv = 0;
        repeat (3) @(negedge clk);                       // stays tripped
        drive(0, 0, 2); drive(1, 0, 3); drive(0, 0, 2);

        cur_req = "R11";
        drive(0, 1, 2);
        ot_flag = 1;
        repeat (3) @(negedge clk);
        hi_cmd = 1; lo_cmd = 0;
        repeat (2) @(negedge clk);
        ot_flag = 0;
        repeat (2) @(negedge clk);
        drive(0, 0, 3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule